// File: doc/BRIEF.md
# Root Port Suspend and Resume Controller

This block manages the low-power states of a single root port. Software asks for suspend through a register write. The block then does one of two things. It can put the port directly into the deep (L2) suspend. It can instead ask the transaction layer to send a link-power-management request to the attached device and wait for the device's handshake, which moves the port into the light (L1) sleep state. A configuration bit chooses between the two, and the L1 path also needs a non-zero device address. The block holds the port's suspend, force-resume, enable and power bits, a sticky change flag, and a two-bit record of how the last L1 request ended.

The port can leave suspend in two ways: software sets force-resume, or the block sees a J-to-K transition on the line while the port is suspended. The exit from L1 is timed by the block. It counts a 1 µs tick input against a duration derived from a 4-bit code that is latched when the request is issued. After that time it clears force-resume and suspend by itself. The exit from L2 is timed by software, which holds force-resume at 1 while resume is driven. After software clears it, the bit stays at 1 until the line reports high-speed idle or a 2 ms guard expires.

Top module: `port_lpm_ctrl`

## Requirements
- R1: After reset every output is 0: suspend, force-resume, enable, power, change flag, L1 status, request, done, resume drive, latched address and code, and `port_state` reads 0 (disabled).
- R2: A write with `cfg_suspend`=1 while the port is enabled and idle, with `cfg_l1_mode`=1 and a non-zero `cfg_dev_addr`, raises `lpm_req` from the next cycle. `lpm_addr` and `lpm_hird` carry the address and duration code latched at that write. `lpm_req` stays high until an outcome is recorded, and suspend reads 0 during that time.
- R3: The same write with `cfg_l1_mode`=0 or a zero address makes suspend read 1 on the next cycle without raising `lpm_req`.
- R4: The handshake code 00 (acknowledge) sets suspend to 1 and the L1 status to 00, and pulses `lpm_done` for one cycle. All of this is visible on the cycle after `hs_valid`.
- R5: The handshake codes 01 (not yet), 10 (stall) and 11 (error) are recorded as the L1 status on the cycle after `hs_valid`. Suspend stays 0, `lpm_req` drops and `lpm_done` pulses for one cycle.
- R6: If no handshake arrives, `lpm_req` stays high for exactly TIMEOUT_CYC cycles. Then the L1 status becomes 11, `lpm_done` pulses, and the port is left enabled and not suspended.
- R7: A write of 0 to suspend changes nothing. A write of 1 to suspend is ignored when the port is disabled or already suspended.
- R8: While the port is suspended, a rising edge on `line_k` sets force-resume and the change flag. A force-resume written by software sets force-resume only. Writing `cfg_clr_change`=1 clears the change flag.
- R9: During an L1 exit, `drive_resume` stays high while tick pulses are counted. On the (50+75*code+1)-th tick, force-resume and suspend clear together and the drive ends. This guarantees at least 50+75*code µs of resume.
- R10: During an L2 exit, `drive_resume` stays high for as long as force-resume is held. A software write of 0 to force-resume stops the drive, but force-resume stays 1 until `hs_idle` is seen or until L2_EXIT_US ticks have passed. Then force-resume and suspend clear.
- R11: When power is 0, suspend, force-resume and enable are forced to 0. A rising edge on `port_reset` clears suspend and force-resume, and any suspend or resume in progress ends.
- R12: `port_state` is 0 when enable is 0, 2 when enable and suspend are both 1, and 1 otherwise. Writing `cfg_enable`=0 clears enable, suspend and force-resume. Enable is set only by `enable_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle software write strobe for the port control fields |
| cfg_suspend | input | 1 | Suspend value written (only 1 has an effect) |
| cfg_force_resume | input | 1 | Force-resume value written |
| cfg_enable | input | 1 | Enable value written (0 disables, 1 has no effect) |
| cfg_power | input | 1 | Port power value written |
| cfg_clr_change | input | 1 | Write 1 to clear the change flag |
| cfg_l1_mode | input | 1 | Selects L1 suspend when a suspend is written |
| cfg_dev_addr | input | 7 | Device address of the port's device |
| cfg_resume_code | input | 4 | Resume duration code for L1 |
| enable_set | input | 1 | Pulse from the reset sequencer that enables the port |
| port_reset | input | 1 | Port reset level |
| hs_valid | input | 1 | Handshake outcome valid |
| hs_code | input | 2 | Outcome: 00 ack, 01 not yet, 10 stall, 11 error |
| line_k | input | 1 | Line is in K state |
| hs_idle | input | 1 | Line is back in high-speed idle |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| st_suspend | output | 1 | Suspend bit |
| st_force_resume | output | 1 | Force-resume bit |
| st_enable | output | 1 | Enable bit |
| st_power | output | 1 | Power bit |
| st_change | output | 1 | Sticky port change flag |
| st_l1_status | output | 2 | Outcome of the last L1 request |
| port_state | output | 2 | 0 disabled, 1 enabled, 2 suspended |
| lpm_req | output | 1 | Request for an L1 token |
| lpm_addr | output | 7 | Device address for the request |
| lpm_hird | output | 4 | Duration code for the request |
| lpm_done | output | 1 | One-cycle pulse when an L1 request ends |
| drive_resume | output | 1 | Drive K resume signalling |

## Verification
Every output is registered. A write, a handshake, a line edge or `hs_idle` shows up on the cycle after the edge that sampled it, and the L1 timeout shows up on the TIMEOUT_CYC-th cycle of the request. Resume completion lands on the edge that samples the final counted tick. The bench drives inputs and compares outputs on the falling clock edge. It steps a behavioural model on each rising edge, using the same sampled inputs, so every comparison looks at the cycle in which the result is due. Resume lengths are also bounded in whole cycles by tick arithmetic: between need*DIV+1 and (need+1)*DIV cycles, where DIV is the tick spacing in clock cycles.

// File: rtl/plpm_pkg.sv
package plpm_pkg;

    typedef enum logic [2:0] {
        PS_IDLE    = 3'd0,
        PS_L1_REQ  = 3'd1,
        PS_L1_SUSP = 3'd2,
        PS_L2_SUSP = 3'd3,
        PS_L1_RES  = 3'd4,
        PS_L2_RES  = 3'd5,
        PS_L2_EXIT = 3'd6
    } plpm_state_e;

    localparam logic [1:0] HS_ACK   = 2'b00;
    localparam logic [1:0] HS_NYET  = 2'b01;
    localparam logic [1:0] HS_STALL = 2'b10;
    localparam logic [1:0] HS_NONE  = 2'b11;

    localparam logic [1:0] PST_OFF  = 2'd0;
    localparam logic [1:0] PST_ON   = 2'd1;
    localparam logic [1:0] PST_SUSP = 2'd2;

endpackage

// File: rtl/plpm_tick_timer.sv
module plpm_tick_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;

    // counts ticks; hit fires on the tick that arrives when limit ticks have already passed
    always_comb begin
        cnt_d = cnt_q;
        hit   = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == limit) hit = 1'b1;
            else                cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/plpm_hs_waiter.sv
module plpm_hs_waiter
    import plpm_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       hs_valid,
    input  logic [1:0] hs_code,
    output logic       finish,
    output logic [1:0] result
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        finish = active && (hs_valid || cnt_q == LAST);
        result = hs_valid ? hs_code : HS_NONE;
        cnt_d  = cnt_q;
        if (!active)      cnt_d = '0;
        else if (!finish) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/plpm_jk_detect.sv
module plpm_jk_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic line_k,
    output logic evt
);
    logic k_d, k_q;

    always_comb begin
        k_d = line_k;
        evt = arm && line_k && !k_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= 1'b0;
        else        k_q <= k_d;
    end
endmodule

// File: rtl/port_lpm_ctrl.sv
module port_lpm_ctrl
    import plpm_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int HIRD_W      = 4,
    parameter int TIMEOUT_CYC = 16,
    parameter int RES_BASE_US = 50,
    parameter int RES_STEP_US = 75,
    parameter int L2_EXIT_US  = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_suspend,
    input  logic              cfg_force_resume,
    input  logic              cfg_enable,
    input  logic              cfg_power,
    input  logic              cfg_clr_change,
    input  logic              cfg_l1_mode,
    input  logic [ADDR_W-1:0] cfg_dev_addr,
    input  logic [HIRD_W-1:0] cfg_resume_code,
    input  logic              enable_set,
    input  logic              port_reset,
    input  logic              hs_valid,
    input  logic [1:0]        hs_code,
    input  logic              line_k,
    input  logic              hs_idle,
    input  logic              tick_1us,
    output logic              st_suspend,
    output logic              st_force_resume,
    output logic              st_enable,
    output logic              st_power,
    output logic              st_change,
    output logic [1:0]        st_l1_status,
    output logic [1:0]        port_state,
    output logic              lpm_req,
    output logic [ADDR_W-1:0] lpm_addr,
    output logic [HIRD_W-1:0] lpm_hird,
    output logic              lpm_done,
    output logic              drive_resume
);
    localparam int L1_MAX_US = RES_BASE_US + RES_STEP_US * ((1 << HIRD_W) - 1);
    localparam int TOP_US    = (L1_MAX_US > L2_EXIT_US) ? L1_MAX_US : L2_EXIT_US;
    localparam int TW        = $clog2(TOP_US + 1);

    typedef struct packed {
        plpm_state_e       state;
        logic              suspend;
        logic              force_res;
        logic              enable;
        logic              power;
        logic              change;
        logic              done;
        logic              rst_prev;
        logic [1:0]        l1_stat;
        logic [ADDR_W-1:0] addr;
        logic [HIRD_W-1:0] hird;
    } regs_t;

    regs_t r_d, r_q;

    logic          hs_active, hs_finish;
    logic [1:0]    hs_result;
    logic          jk_arm, jk_evt;
    logic          t_clr, t_hit;
    logic [TW-1:0] t_limit, l1_limit, l2_limit;
    logic          pw_next, rst_rise;

    assign hs_active = (r_q.state == PS_L1_REQ);
    assign jk_arm    = (r_q.state == PS_L1_SUSP) || (r_q.state == PS_L2_SUSP);
    assign t_clr     = !((r_q.state == PS_L1_RES) || (r_q.state == PS_L2_EXIT));
    assign l1_limit  = TW'(RES_BASE_US + RES_STEP_US * int'(r_q.hird));
    assign l2_limit  = TW'(L2_EXIT_US - 1);
    assign t_limit   = (r_q.state == PS_L1_RES) ? l1_limit : l2_limit;

    plpm_hs_waiter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_hs (
        .clk(clk), .rst_n(rst_n), .active(hs_active), .hs_valid(hs_valid),
        .hs_code(hs_code), .finish(hs_finish), .result(hs_result)
    );

    plpm_jk_detect u_jk (
        .clk(clk), .rst_n(rst_n), .arm(jk_arm), .line_k(line_k), .evt(jk_evt)
    );

    plpm_tick_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(t_clr), .tick(tick_1us),
        .limit(t_limit), .hit(t_hit)
    );

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.rst_prev = port_reset;
        pw_next      = cfg_wr ? cfg_power : r_q.power;
        r_d.power    = pw_next;
        rst_rise     = port_reset && !r_q.rst_prev;
        if (cfg_wr && cfg_clr_change) r_d.change = 1'b0;

        if (!pw_next) begin
            r_d.suspend   = 1'b0;
            r_d.force_res = 1'b0;
            r_d.enable    = 1'b0;
            r_d.state     = PS_IDLE;
        end else if (rst_rise) begin
            r_d.suspend   = 1'b0;
            r_d.force_res = 1'b0;
            r_d.state     = PS_IDLE;
        end else if (cfg_wr && !cfg_enable) begin
            r_d.enable    = 1'b0;
            r_d.suspend   = 1'b0;
            r_d.force_res = 1'b0;
            r_d.state     = PS_IDLE;
        end else begin
            if (enable_set) r_d.enable = 1'b1;
            unique case (r_q.state)
                PS_IDLE: begin
                    if (cfg_wr && cfg_suspend && r_q.enable) begin
                        if (cfg_l1_mode && cfg_dev_addr != '0) begin
                            r_d.state = PS_L1_REQ;
                            r_d.addr  = cfg_dev_addr;
                            r_d.hird  = cfg_resume_code;
                        end else begin
                            r_d.suspend = 1'b1;
                            r_d.state   = PS_L2_SUSP;
                        end
                    end
                end
                PS_L1_REQ: begin
                    if (hs_finish) begin
                        r_d.done    = 1'b1;
                        r_d.l1_stat = hs_result;
                        if (hs_result == HS_ACK) begin
                            r_d.suspend = 1'b1;
                            r_d.state   = PS_L1_SUSP;
                        end else begin
                            r_d.state = PS_IDLE;
                        end
                    end
                end
                PS_L1_SUSP, PS_L2_SUSP: begin
                    if (jk_evt || (cfg_wr && cfg_force_resume)) begin
                        r_d.force_res = 1'b1;
                        if (jk_evt) r_d.change = 1'b1;
                        r_d.state = (r_q.state == PS_L1_SUSP) ? PS_L1_RES : PS_L2_RES;
                    end
                end
                PS_L1_RES: begin
                    if (t_hit) begin
                        r_d.force_res = 1'b0;
                        r_d.suspend   = 1'b0;
                        r_d.state     = PS_IDLE;
                    end
                end
                PS_L2_RES: begin
                    if (cfg_wr && !cfg_force_resume) r_d.state = PS_L2_EXIT;
                end
                PS_L2_EXIT: begin
                    if (hs_idle || t_hit) begin
                        r_d.force_res = 1'b0;
                        r_d.suspend   = 1'b0;
                        r_d.state     = PS_IDLE;
                    end
                end
                default: r_d.state = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        st_suspend      = r_q.suspend;
        st_force_resume = r_q.force_res;
        st_enable       = r_q.enable;
        st_power        = r_q.power;
        st_change       = r_q.change;
        st_l1_status    = r_q.l1_stat;
        lpm_req         = (r_q.state == PS_L1_REQ);
        lpm_addr        = r_q.addr;
        lpm_hird        = r_q.hird;
        lpm_done        = r_q.done;
        drive_resume    = (r_q.state == PS_L1_RES) || (r_q.state == PS_L2_RES);
        if (!r_q.enable)      port_state = PST_OFF;
        else if (r_q.suspend) port_state = PST_SUSP;
        else                  port_state = PST_ON;
    end

    // R4: a done pulse only follows a cycle with an open request
    p_done_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_done |-> $past(lpm_req));

    // R5: the recorded outcome moves only together with the done pulse
    p_status_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_l1_status) |-> lpm_done);

    // R5: a refused request never leaves the port suspended
    p_reject_no_susp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_done && st_l1_status != HS_ACK) |-> !st_suspend);

    // R8: the change flag rises only with a new force-resume
    p_change_with_fr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_change) |-> $rose(st_force_resume));

    // R9: resume signalling is driven only while force-resume is set
    p_drive_has_fr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drive_resume |-> st_force_resume);

    // R11: an unpowered port holds no suspend, resume or enable
    p_power_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !st_power |-> (!st_suspend && !st_force_resume && !st_enable));

    // R12: suspend can only be held by an enabled port
    p_susp_needs_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_suspend |-> st_enable);

endmodule

// File: tb/test_port_lpm_ctrl.sv
module test_port_lpm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TO_CYC     = 16;
    localparam int L2_US      = 2000;
    localparam int DIV        = 4;

    localparam int M_IDLE = 0, M_REQ = 1, M_L1S = 2, M_L2S = 3, M_L1R = 4, M_L2R = 5, M_L2X = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 0, cfg_suspend = 0, cfg_force_resume = 0, cfg_enable = 1, cfg_power = 1;
    logic cfg_clr_change = 0, cfg_l1_mode = 0;
    logic [6:0] cfg_dev_addr = '0;
    logic [3:0] cfg_resume_code = '0;
    logic enable_set = 0, port_reset = 0, hs_valid = 0, line_k = 0, hs_idle = 0, tick_1us = 0;
    logic [1:0] hs_code = '0;

    logic st_suspend, st_force_resume, st_enable, st_power, st_change, lpm_req, lpm_done, drive_resume;
    logic [1:0] st_l1_status, port_state;
    logic [6:0] lpm_addr;
    logic [3:0] lpm_hird;

    int n_cmp = 0, n_bad = 0, tdiv = 0;
    string cur_req = "R1";
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_lpm_ctrl #(.TIMEOUT_CYC(TO_CYC), .L2_EXIT_US(L2_US)) i_port_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_suspend(cfg_suspend),
        .cfg_force_resume(cfg_force_resume), .cfg_enable(cfg_enable), .cfg_power(cfg_power),
        .cfg_clr_change(cfg_clr_change), .cfg_l1_mode(cfg_l1_mode), .cfg_dev_addr(cfg_dev_addr),
        .cfg_resume_code(cfg_resume_code), .enable_set(enable_set), .port_reset(port_reset),
        .hs_valid(hs_valid), .hs_code(hs_code), .line_k(line_k), .hs_idle(hs_idle),
        .tick_1us(tick_1us), .st_suspend(st_suspend), .st_force_resume(st_force_resume),
        .st_enable(st_enable), .st_power(st_power), .st_change(st_change),
        .st_l1_status(st_l1_status), .port_state(port_state), .lpm_req(lpm_req),
        .lpm_addr(lpm_addr), .lpm_hird(lpm_hird), .lpm_done(lpm_done), .drive_resume(drive_resume)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // tick source: one pulse every DIV cycles
    always @(negedge clk) begin
        tick_1us <= (tdiv == DIV - 1);
        tdiv = (tdiv + 1) % DIV;
    end

    // behavioural reference model
    int m_mode, m_susp, m_fr, m_en, m_pw, m_chg, m_stat, m_done, m_addr, m_hird;
    int m_cnt, m_ticks, m_kprev, m_rprev;

    always @(posedge clk) begin
        int pw, jk, rr, old_en, need;
        if (!rst_n) begin
            m_mode = M_IDLE; m_susp = 0; m_fr = 0; m_en = 0; m_pw = 0; m_chg = 0; m_stat = 0;
            m_done = 0; m_addr = 0; m_hird = 0; m_cnt = 0; m_ticks = 0; m_kprev = 0; m_rprev = 0;
        end else begin
            jk = (line_k && !m_kprev) ? 1 : 0;
            rr = (port_reset && !m_rprev) ? 1 : 0;
            m_kprev = line_k; m_rprev = port_reset;
            old_en = m_en;
            m_done = 0;
            pw = cfg_wr ? int'(cfg_power) : m_pw;
            m_pw = pw;
            if (cfg_wr && cfg_clr_change) m_chg = 0;
            if (pw == 0) begin
                m_susp = 0; m_fr = 0; m_en = 0; m_mode = M_IDLE;
            end else if (rr != 0) begin
                m_susp = 0; m_fr = 0; m_mode = M_IDLE;
            end else if (cfg_wr && !cfg_enable) begin
                m_en = 0; m_susp = 0; m_fr = 0; m_mode = M_IDLE;
            end else begin
                if (enable_set) m_en = 1;
                case (m_mode)
                    M_IDLE: if (cfg_wr && cfg_suspend && old_en != 0) begin
                        if (cfg_l1_mode && cfg_dev_addr != 0) begin
                            m_mode = M_REQ; m_cnt = 0; m_addr = cfg_dev_addr; m_hird = cfg_resume_code;
                        end else begin
                            m_susp = 1; m_mode = M_L2S;
                        end
                    end
                    M_REQ: begin
                        if (hs_valid) begin
                            m_stat = hs_code; m_done = 1;
                            if (hs_code == 0) begin m_susp = 1; m_mode = M_L1S; end
                            else m_mode = M_IDLE;
                        end else if (m_cnt == TO_CYC - 1) begin
                            m_stat = 3; m_done = 1; m_mode = M_IDLE;
                        end else m_cnt++;
                    end
                    M_L1S, M_L2S: if (jk != 0 || (cfg_wr && cfg_force_resume)) begin
                        m_fr = 1; m_ticks = 0;
                        if (jk != 0) m_chg = 1;
                        m_mode = (m_mode == M_L1S) ? M_L1R : M_L2R;
                    end
                    M_L1R: if (tick_1us) begin
                        need = 50 + 75 * m_hird;
                        if (m_ticks == need) begin m_fr = 0; m_susp = 0; m_mode = M_IDLE; end
                        else m_ticks++;
                    end
                    M_L2R: if (cfg_wr && !cfg_force_resume) begin m_mode = M_L2X; m_ticks = 0; end
                    M_L2X: begin
                        if (hs_idle) begin m_fr = 0; m_susp = 0; m_mode = M_IDLE; end
                        else if (tick_1us) begin
                            if (m_ticks == L2_US - 1) begin m_fr = 0; m_susp = 0; m_mode = M_IDLE; end
                            else m_ticks++;
                        end
                    end
                    default: m_mode = M_IDLE;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk(cur_req, "suspend", st_suspend, m_susp);
            chk(cur_req, "force_resume", st_force_resume, m_fr);
            chk(cur_req, "enable", st_enable, m_en);
            chk(cur_req, "power", st_power, m_pw);
            chk(cur_req, "change", st_change, m_chg);
            chk(cur_req, "l1_status", st_l1_status, m_stat);
            chk(cur_req, "done", lpm_done, m_done);
            chk(cur_req, "req", lpm_req, (m_mode == M_REQ) ? 1 : 0);
            chk(cur_req, "drive", drive_resume, (m_mode == M_L1R || m_mode == M_L2R) ? 1 : 0);
            chk(cur_req, "addr", lpm_addr, m_addr);
            chk(cur_req, "hird", lpm_hird, m_hird);
            chk(cur_req, "state", port_state, (m_en == 0) ? 0 : (m_susp != 0 ? 2 : 1));
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    task automatic wr(input bit susp, input bit fr, input bit en = 1, input bit pw = 1, input bit clr = 0);
        @(negedge clk);
        cfg_suspend = susp; cfg_force_resume = fr; cfg_enable = en; cfg_power = pw;
        cfg_clr_change = clr; cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0; cfg_clr_change = 0;
    endtask

    task automatic hs(input logic [1:0] c);
        @(negedge clk); hs_valid = 1; hs_code = c;
        @(negedge clk); hs_valid = 0;
    endtask

    task automatic en_pulse();
        @(negedge clk); enable_set = 1;
        @(negedge clk); enable_set = 0;
    endtask

    task automatic kedge();
        @(negedge clk); line_k = 1;
        @(negedge clk); line_k = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int n;
        idle(3);
        cur_req = "R1";
        chk("R1", "suspend", st_suspend, 0); chk("R1", "power", st_power, 0);
        chk("R1", "state", port_state, 0); chk("R1", "req", lpm_req, 0);
        @(negedge clk); rst_n = 1;
        idle(2);
        chk("R1", "state after release", port_state, 0);

        // R7: suspend on a disabled port is ignored
        cur_req = "R7";
        wr(1, 0);
        chk("R7", "suspend while disabled", st_suspend, 0);
        en_pulse();
        cur_req = "R12";
        chk("R12", "state enabled", port_state, 1);
        cur_req = "R7";
        wr(0, 0);
        chk("R7", "write of 0", st_suspend, 0);

        // R3: legacy suspend
        cur_req = "R3";
        cfg_l1_mode = 0; cfg_dev_addr = 7'h12;
        wr(1, 0);
        chk("R3", "suspend", st_suspend, 1); chk("R3", "no req", lpm_req, 0);
        chk("R12", "state suspended", port_state, 2);
        wr(1, 0);
        chk("R7", "second suspend ignored", port_state, 2);

        // R8 + R10: software resume of L2 ends on line idle
        cur_req = "R10";
        wr(0, 1);
        chk("R8", "sw fr sets fr", st_force_resume, 1);
        chk("R8", "sw fr no change", st_change, 0);
        chk("R10", "drive", drive_resume, 1);
        idle(10);
        chk("R10", "drive held", drive_resume, 1);
        wr(0, 0);
        chk("R10", "drive stops", drive_resume, 0);
        chk("R10", "fr held", st_force_resume, 1);
        idle(5);
        @(negedge clk); hs_idle = 1;
        @(negedge clk); hs_idle = 0;
        chk("R10", "fr cleared", st_force_resume, 0);
        chk("R10", "suspend cleared", st_suspend, 0);

        // R8 + R10: remote wake on L2, exit guard expiry
        cur_req = "R8";
        wr(1, 0);
        kedge();
        chk("R8", "jk fr", st_force_resume, 1); chk("R8", "jk change", st_change, 1);
        wr(0, 1, 1, 1, 1);
        chk("R8", "change cleared", st_change, 0);
        cur_req = "R10";
        wr(0, 0);
        n = 0;
        while (st_force_resume && n < 10000) begin n++; @(negedge clk); end
        chk("R10", "guard lower", (n >= (L2_US - 1) * DIV + 1) ? 1 : 0, 1);
        chk("R10", "guard upper", (n <= L2_US * DIV) ? 1 : 0, 1);

        // R2 + R4: L1 request acknowledged
        cur_req = "R2";
        cfg_l1_mode = 1; cfg_dev_addr = 7'h25; cfg_resume_code = 4'd3;
        wr(1, 0);
        chk("R2", "req", lpm_req, 1); chk("R2", "addr", lpm_addr, 'h25);
        chk("R2", "hird", lpm_hird, 3); chk("R2", "suspend low", st_suspend, 0);
        cfg_resume_code = 4'd9;
        idle(3);
        chk("R2", "req held", lpm_req, 1);
        cur_req = "R4";
        hs(2'b00);
        chk("R4", "suspend", st_suspend, 1); chk("R4", "status", st_l1_status, 0);
        chk("R4", "done", lpm_done, 1);
        @(negedge clk);
        chk("R4", "done one cycle", lpm_done, 0);

        // R9: remote wake from L1, timed exit with code 3
        cur_req = "R9";
        kedge();
        chk("R9", "drive", drive_resume, 1); chk("R8", "l1 change", st_change, 1);
        n = 0;
        while (drive_resume && n < 20000) begin n++; @(negedge clk); end
        chk("R9", "len lower", (n >= (50 + 75 * 3) * DIV) ? 1 : 0, 1);
        chk("R9", "len upper", (n <= (51 + 75 * 3) * DIV) ? 1 : 0, 1);
        chk("R9", "fr cleared", st_force_resume, 0); chk("R9", "susp cleared", st_suspend, 0);

        // R9: code 0 with software resume
        cfg_resume_code = 4'd0;
        wr(1, 0, 1, 1, 1);
        hs(2'b00);
        wr(0, 1);
        chk("R8", "sw fr on L1 no change", st_change, 0);
        n = 0;
        while (drive_resume && n < 20000) begin n++; @(negedge clk); end
        chk("R9", "code0 lower", (n >= 50 * DIV - 1) ? 1 : 0, 1);
        chk("R9", "code0 upper", (n <= 51 * DIV) ? 1 : 0, 1);

        // R6: timeout
        cur_req = "R6";
        wr(1, 0);
        n = 0;
        while (lpm_req && n < 100) begin n++; @(negedge clk); end
        chk("R6", "req cycles", n, TO_CYC);
        chk("R6", "status", st_l1_status, 3); chk("R6", "done", lpm_done, 1);
        chk("R6", "state enabled", port_state, 1);

        // R5: refused requests
        cur_req = "R5";
        wr(1, 0); hs(2'b01);
        chk("R5", "nyet status", st_l1_status, 1); chk("R5", "nyet susp", st_suspend, 0);
        chk("R5", "nyet done", lpm_done, 1); chk("R5", "nyet req", lpm_req, 0);
        wr(1, 0); hs(2'b10);
        chk("R5", "stall status", st_l1_status, 2); chk("R5", "stall susp", st_suspend, 0);
        wr(1, 0); hs(2'b00);
        wr(1, 0, 1, 1, 0);
        chk("R7", "suspend on L1 ignored", lpm_req, 0);
        wr(0, 1);
        idle(300);
        wr(1, 0); hs(2'b11);
        chk("R5", "error status", st_l1_status, 3); chk("R5", "error done", lpm_done, 1);

        // R3: zero address selects L2 even in L1 mode
        cur_req = "R3";
        cfg_dev_addr = '0;
        wr(1, 0);
        chk("R3", "zero addr suspend", st_suspend, 1); chk("R3", "zero addr req", lpm_req, 0);

        // R11: port reset edge, power off
        cur_req = "R11";
        @(negedge clk); port_reset = 1;
        @(negedge clk);
        chk("R11", "reset clears suspend", st_suspend, 0);
        chk("R11", "reset keeps enable", st_enable, 1);
        port_reset = 0;
        wr(1, 0);
        wr(0, 0, 1, 0);
        chk("R11", "power off suspend", st_suspend, 0);
        chk("R11", "power off enable", st_enable, 0);
        chk("R11", "power off state", port_state, 0);
        wr(0, 0, 1, 1);
        en_pulse();

        // R12: software disable while L1 suspended
        cur_req = "R12";
        cfg_dev_addr = 7'h44;
        wr(1, 0); hs(2'b00);
        chk("R12", "suspended", port_state, 2);
        wr(0, 0, 0, 1);
        chk("R12", "disabled", port_state, 0); chk("R12", "suspend cleared", st_suspend, 0);
        idle(4);
        finish_run();
    end
endmodule